// File: doc/BRIEF.md
# Template-Routed Bundle Dispatcher

This block sits between instruction fetch and a fixed set of functional-unit ports. Each cycle it may take one or two 128-bit bundles from fetch through a valid/ready handshake. Every bundle carries three 41-bit instruction slots and a 5-bit template. The template says which kind of unit each slot needs and where the compiler placed group stops. The dispatcher does not look at opcodes. It walks the slots in program order and gives each one to the lowest free port of its class. It stops at the first group stop, or at the first slot whose class has no free port left in that cycle.

There are two memory ports, two integer ports, two floating-point ports and three branch ports. Slots that cannot leave in the accepting cycle are held. They drain on later cycles, and fetch is stalled until the held slots are gone, so issue never leaves program order. A bundle whose template is not in the supported table is dropped and raises a one-cycle fault. All port outputs are registered.

Top module: `bdu_dispatch`

## Requirements
- R1: The template occupies bits 4:0, and the slots occupy bits 45:5, 86:46 and 127:87 for slots 0, 1 and 2. Template bit 0 marks a stop after slot 2. Bits 4:1 choose the slot classes. 0 is M,I,I. 1 is M,I,I with a stop after slot 1. 2 is M,L,X. 4 is M,M,I. 5 is M,M,I with a stop after slot 0. 6 is M,F,I. 7 is M,M,F. 8 is M,I,B. 9 is M,B,B. 11 is B,B,B. 12 is M,M,B. 14 is M,F,B. The values 3, 10, 13 and 15 are illegal.
- R2: Slots are considered in program order, bundle 0 before bundle 1. Each slot goes to the lowest-numbered free port of its class. M slots use memory ports, I slots use integer ports, F slots use floating-point ports and B slots use branch ports.
- R3: When neither a stop nor a port shortage intervenes, both bundles of a pair issue in the cycle that follows acceptance.
- R4: A slot marked with a stop after it ends issue for that cycle. The following slot, in the same or the next bundle, issues in a later cycle.
- R5: When a slot's class has no free port left in the cycle, that slot and every later slot wait for a later cycle.
- R6: Slots that are left over stay held and issue in the following cycles. While any slot is held, in_ready_o is low and no new bundle is accepted. A valid input offered during that time issues only after the held slots.
- R7: A bundle with an illegal template issues nothing. fault_o is high for exactly the one cycle after the bundle is accepted. The other bundle of the pair issues normally.
- R8: An M, I, F or B slot whose 41 bits are all zero is a no-operation. It consumes a port but leaves that port's valid low, so the next slot of the same class takes the following port.
- R9: An L slot together with the X slot that follows it needs two free integer ports, and both issue in the same cycle on adjacent integer ports with valid high. If fewer than two integer ports are free, the L slot waits.
- R10: While rst_ni is low, and until two rising clock edges after it rises, in_ready_o is low, all port valids are low and fault_o is low.
- R11: Port outputs are registered. A slot issued in a cycle appears on its port in the next cycle, and its valid lasts one cycle only. With no held slots and no valid input, no port valid is raised in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Fetch offers bundle 0 (and bundle 1 if dual) |
| in_dual_i | input | 1 | Bundle 1 is also present |
| in_bundle0_i | input | 128 | Older bundle of the pair |
| in_bundle1_i | input | 128 | Younger bundle of the pair |
| in_ready_o | output | 1 | Dispatcher can accept a pair this cycle |
| mem_valid_o | output | N_MEM (2) | Memory port valids |
| mem_inst_o | output | N_MEM x 41 | Memory port instructions |
| int_valid_o | output | N_INT (2) | Integer port valids |
| int_inst_o | output | N_INT x 41 | Integer port instructions |
| fp_valid_o | output | N_FP (2) | Floating-point port valids |
| fp_inst_o | output | N_FP x 41 | Floating-point port instructions |
| br_valid_o | output | N_BR (3) | Branch port valids |
| br_inst_o | output | N_BR x 41 | Branch port instructions |
| fault_o | output | 1 | Illegal template seen in the accepted pair |

## Verification
The hardest condition to reach from the ports is an input that is held valid while slots are still draining. This is the only situation in which the stall can be seen, and in which order could be broken. To reach it, a pair is sent whose second bundle runs out of memory ports. In the very next cycle a different bundle is offered with valid high, and it is left there. The bench then checks that this bundle appears only after the held slots have left. A second corner case is an L/X pair that finds only one integer port free. It is set up by placing an integer slot in the first bundle of the pair, and the bench checks that the L/X pair waits.

// File: rtl/bdu_pkg.sv
`timescale 1ns/1ps
package bdu_pkg;
  localparam int SLOT_W    = 41;
  localparam int TMPL_W    = 5;
  localparam int BUNDLE_W  = TMPL_W + 3 * SLOT_W;
  localparam int PAIR_SLOTS = 6;
  localparam int HEAD_W    = 3;

  typedef enum logic [2:0] {CL_M, CL_I, CL_F, CL_B, CL_L, CL_X} unit_cls_e;

  typedef struct packed {
    logic              present;
    unit_cls_e         cls;
    logic              stop;
    logic [SLOT_W-1:0] raw;
  } slot_t;

  typedef struct packed {
    logic      legal;
    unit_cls_e c0;
    unit_cls_e c1;
    unit_cls_e c2;
    logic [2:0] stop;
  } tmpl_info_t;

  function automatic tmpl_info_t tmpl_lookup(input logic [TMPL_W-1:0] t);
    tmpl_info_t r;
    r.legal = 1'b1;
    r.c0    = CL_M;
    r.c1    = CL_I;
    r.c2    = CL_I;
    r.stop  = {t[0], 2'b00};
    case (t[4:1])
      4'd0:  ;
      4'd1:  r.stop[1] = 1'b1;
      4'd2:  begin r.c1 = CL_L; r.c2 = CL_X; end
      4'd4:  r.c1 = CL_M;
      4'd5:  begin r.c1 = CL_M; r.stop[0] = 1'b1; end
      4'd6:  r.c1 = CL_F;
      4'd7:  begin r.c1 = CL_M; r.c2 = CL_F; end
      4'd8:  r.c2 = CL_B;
      4'd9:  begin r.c1 = CL_B; r.c2 = CL_B; end
      4'd11: begin r.c0 = CL_B; r.c1 = CL_B; r.c2 = CL_B; end
      4'd12: begin r.c1 = CL_M; r.c2 = CL_B; end
      4'd14: begin r.c1 = CL_F; r.c2 = CL_B; end
      default: r.legal = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/bdu_tmpl_dec.sv
`timescale 1ns/1ps
module bdu_tmpl_dec
  import bdu_pkg::*;
(
  input  logic [BUNDLE_W-1:0] bundle_i,
  input  logic                avail_i,
  output slot_t [2:0]         slot_o,
  output logic                illegal_o
);
  tmpl_info_t info;
  unit_cls_e  cls_a [3];

  always_comb begin
    info     = tmpl_lookup(bundle_i[TMPL_W-1:0]);
    cls_a[0] = info.c0;
    cls_a[1] = info.c1;
    cls_a[2] = info.c2;
  end

  assign illegal_o = avail_i & ~info.legal;

  for (genvar k = 0; k < 3; k++) begin : g_slot
    assign slot_o[k].present = avail_i & info.legal;
    assign slot_o[k].cls     = cls_a[k];
    assign slot_o[k].stop    = info.stop[k];
    assign slot_o[k].raw     = bundle_i[TMPL_W + k*SLOT_W +: SLOT_W];
  end
endmodule

// File: rtl/bdu_issue_sel.sv
`timescale 1ns/1ps
module bdu_issue_sel
  import bdu_pkg::*;
#(
  parameter int N_MEM = 2,
  parameter int N_INT = 2,
  parameter int N_FP  = 2,
  parameter int N_BR  = 3
) (
  input  slot_t [PAIR_SLOTS-1:0]   slots_i,
  input  logic  [HEAD_W-1:0]       head_i,
  output logic  [N_MEM-1:0]        mem_v_o,
  output logic  [N_MEM-1:0][SLOT_W-1:0] mem_inst_o,
  output logic  [N_INT-1:0]        int_v_o,
  output logic  [N_INT-1:0][SLOT_W-1:0] int_inst_o,
  output logic  [N_FP-1:0]         fp_v_o,
  output logic  [N_FP-1:0][SLOT_W-1:0]  fp_inst_o,
  output logic  [N_BR-1:0]         br_v_o,
  output logic  [N_BR-1:0][SLOT_W-1:0]  br_inst_o,
  output logic                     rem_o,
  output logic  [HEAD_W-1:0]       next_head_o
);
  logic [N_MEM-1:0] m_used;
  logic [N_INT-1:0] i_used;
  logic [N_FP-1:0]  f_used;
  logic [N_BR-1:0]  b_used;
  logic [PAIR_SLOTS-1:0] take;
  logic blocked, placed, live, nop;

  always_comb begin
    m_used = '0; i_used = '0; f_used = '0; b_used = '0;
    mem_v_o = '0; mem_inst_o = '0;
    int_v_o = '0; int_inst_o = '0;
    fp_v_o  = '0; fp_inst_o  = '0;
    br_v_o  = '0; br_inst_o  = '0;
    take = '0;
    blocked = 1'b0;
    placed = 1'b0;
    live = 1'b0;
    nop = 1'b0;
    for (int k = 0; k < PAIR_SLOTS; k++) begin
      live   = slots_i[k].present && (k >= int'(head_i)) && !blocked;
      nop    = ~|slots_i[k].raw;
      placed = 1'b0;
      if (live) begin
        case (slots_i[k].cls)
          CL_M: for (int p = 0; p < N_MEM; p++)
                  if (!placed && !m_used[p]) begin
                    m_used[p] = 1'b1; mem_v_o[p] = !nop;
                    mem_inst_o[p] = slots_i[k].raw; placed = 1'b1;
                  end
          CL_I, CL_X: for (int p = 0; p < N_INT; p++)
                  if (!placed && !i_used[p]) begin
                    i_used[p] = 1'b1;
                    int_v_o[p] = (slots_i[k].cls == CL_X) || !nop;
                    int_inst_o[p] = slots_i[k].raw; placed = 1'b1;
                  end
          CL_L: if (!i_used[N_INT-2])
                  for (int p = 0; p < N_INT; p++)
                    if (!placed && !i_used[p]) begin
                      i_used[p] = 1'b1; int_v_o[p] = 1'b1;
                      int_inst_o[p] = slots_i[k].raw; placed = 1'b1;
                    end
          CL_F: for (int p = 0; p < N_FP; p++)
                  if (!placed && !f_used[p]) begin
                    f_used[p] = 1'b1; fp_v_o[p] = !nop;
                    fp_inst_o[p] = slots_i[k].raw; placed = 1'b1;
                  end
          CL_B: for (int p = 0; p < N_BR; p++)
                  if (!placed && !b_used[p]) begin
                    b_used[p] = 1'b1; br_v_o[p] = !nop;
                    br_inst_o[p] = slots_i[k].raw; placed = 1'b1;
                  end
          default: ;
        endcase
        take[k] = placed;
        if (!placed || slots_i[k].stop) blocked = 1'b1;
      end
    end
  end

  always_comb begin
    rem_o       = 1'b0;
    next_head_o = head_i;
    for (int k = 0; k < PAIR_SLOTS; k++) begin
      if (take[k]) next_head_o = HEAD_W'(k + 1);
      if (slots_i[k].present && (k >= int'(head_i)) && !take[k]) rem_o = 1'b1;
    end
  end
endmodule

// File: rtl/bdu_port_reg.sv
`timescale 1ns/1ps
module bdu_port_reg #(
  parameter int N = 2,
  parameter int W = 41
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic [N-1:0]      valid_i,
  input  logic [N-1:0][W-1:0] inst_i,
  output logic [N-1:0]      valid_o,
  output logic [N-1:0][W-1:0] inst_o
);
  logic [N-1:0]        valid_d, valid_q;
  logic [N-1:0][W-1:0] inst_q;
  logic [N-1:0]        cap_en;

  assign valid_d = fire_i ? valid_i : '0;
  assign cap_en  = fire_i ? valid_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else         valid_q <= valid_d;
  end

  always_ff @(posedge clk_i) begin
    for (int p = 0; p < N; p++)
      if (cap_en[p]) inst_q[p] <= inst_i[p];
  end

  assign valid_o = valid_q;
  assign inst_o  = inst_q;
endmodule

// File: rtl/bdu_dispatch.sv
`timescale 1ns/1ps
module bdu_dispatch
  import bdu_pkg::*;
#(
  parameter int N_MEM = 2,
  parameter int N_INT = 2,
  parameter int N_FP  = 2,
  parameter int N_BR  = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          in_valid_i,
  input  logic                          in_dual_i,
  input  logic [127:0]                  in_bundle0_i,
  input  logic [127:0]                  in_bundle1_i,
  output logic                          in_ready_o,
  output logic [N_MEM-1:0]              mem_valid_o,
  output logic [N_MEM-1:0][40:0]        mem_inst_o,
  output logic [N_INT-1:0]              int_valid_o,
  output logic [N_INT-1:0][40:0]        int_inst_o,
  output logic [N_FP-1:0]               fp_valid_o,
  output logic [N_FP-1:0][40:0]         fp_inst_o,
  output logic [N_BR-1:0]               br_valid_o,
  output logic [N_BR-1:0][40:0]         br_inst_o,
  output logic                          fault_o
);
  // reset: asserted asynchronously, released after two edges
  logic [1:0] rst_pipe;
  logic       rst_n_s;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe <= 2'b00;
    else         rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  // decode both bundles
  logic [1:0][BUNDLE_W-1:0] bundles;
  logic [1:0]               avail, illegal;
  slot_t [1:0][2:0]         dec_slots;
  slot_t [PAIR_SLOTS-1:0]   in_slots;

  assign bundles = {in_bundle1_i, in_bundle0_i};
  assign avail   = {in_valid_i & in_dual_i, in_valid_i};

  for (genvar b = 0; b < 2; b++) begin : g_dec
    bdu_tmpl_dec u_dec (
      .bundle_i (bundles[b]),
      .avail_i  (avail[b]),
      .slot_o   (dec_slots[b]),
      .illegal_o(illegal[b])
    );
  end
  assign in_slots = {dec_slots[1], dec_slots[0]};

  // hold state
  logic                   hold_q, hold_d;
  slot_t [PAIR_SLOTS-1:0] hold_slots_q;
  logic [HEAD_W-1:0]      head_q, head_d;
  logic                   hold_load_en;
  logic                   fault_q, fault_d;
  logic                   accept, fire;
  slot_t [PAIR_SLOTS-1:0] src_slots;
  logic [HEAD_W-1:0]      src_head;
  logic                   rem;
  logic [HEAD_W-1:0]      next_head;

  assign in_ready_o = rst_n_s & ~hold_q;
  assign accept     = in_valid_i & in_ready_o;
  assign fire       = hold_q | accept;
  assign src_slots  = hold_q ? hold_slots_q : in_slots;
  assign src_head   = hold_q ? head_q : '0;

  logic [N_MEM-1:0]             sel_mem_v;
  logic [N_MEM-1:0][SLOT_W-1:0] sel_mem_inst;
  logic [N_INT-1:0]             sel_int_v;
  logic [N_INT-1:0][SLOT_W-1:0] sel_int_inst;
  logic [N_FP-1:0]              sel_fp_v;
  logic [N_FP-1:0][SLOT_W-1:0]  sel_fp_inst;
  logic [N_BR-1:0]              sel_br_v;
  logic [N_BR-1:0][SLOT_W-1:0]  sel_br_inst;

  bdu_issue_sel #(.N_MEM(N_MEM), .N_INT(N_INT), .N_FP(N_FP), .N_BR(N_BR)) u_sel (
    .slots_i    (src_slots),
    .head_i     (src_head),
    .mem_v_o    (sel_mem_v),
    .mem_inst_o (sel_mem_inst),
    .int_v_o    (sel_int_v),
    .int_inst_o (sel_int_inst),
    .fp_v_o     (sel_fp_v),
    .fp_inst_o  (sel_fp_inst),
    .br_v_o     (sel_br_v),
    .br_inst_o  (sel_br_inst),
    .rem_o      (rem),
    .next_head_o(next_head)
  );

  always_comb begin
    hold_d       = hold_q;
    head_d       = head_q;
    hold_load_en = 1'b0;
    if (hold_q) begin
      if (rem) head_d = next_head;
      else     hold_d = 1'b0;
    end else if (accept && rem) begin
      hold_d       = 1'b1;
      head_d       = next_head;
      hold_load_en = 1'b1;
    end
    fault_d = accept & (|illegal);
  end

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) begin
      hold_q  <= 1'b0;
      head_q  <= '0;
      fault_q <= 1'b0;
    end else begin
      hold_q  <= hold_d;
      head_q  <= head_d;
      fault_q <= fault_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (hold_load_en) hold_slots_q <= in_slots;
  end

  assign fault_o = fault_q;

  bdu_port_reg #(.N(N_MEM), .W(SLOT_W)) u_mem_ports (
    .clk_i(clk_i), .rst_ni(rst_n_s), .fire_i(fire),
    .valid_i(sel_mem_v), .inst_i(sel_mem_inst),
    .valid_o(mem_valid_o), .inst_o(mem_inst_o));
  bdu_port_reg #(.N(N_INT), .W(SLOT_W)) u_int_ports (
    .clk_i(clk_i), .rst_ni(rst_n_s), .fire_i(fire),
    .valid_i(sel_int_v), .inst_i(sel_int_inst),
    .valid_o(int_valid_o), .inst_o(int_inst_o));
  bdu_port_reg #(.N(N_FP), .W(SLOT_W)) u_fp_ports (
    .clk_i(clk_i), .rst_ni(rst_n_s), .fire_i(fire),
    .valid_i(sel_fp_v), .inst_i(sel_fp_inst),
    .valid_o(fp_valid_o), .inst_o(fp_inst_o));
  bdu_port_reg #(.N(N_BR), .W(SLOT_W)) u_br_ports (
    .clk_i(clk_i), .rst_ni(rst_n_s), .fire_i(fire),
    .valid_i(sel_br_v), .inst_i(sel_br_inst),
    .valid_o(br_valid_o), .inst_o(br_inst_o));

  // R6
  hold_progress_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    hold_q |=> (!hold_q || (head_q > $past(head_q))));

  // R6
  hold_load_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    $rose(hold_q) |-> $past(accept));

  // R7
  fault_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    fault_o |-> $past(accept));

  // R11
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (!hold_q && !in_valid_i) |=> (mem_valid_o == '0 && int_valid_o == '0 &&
                                  fp_valid_o == '0 && br_valid_o == '0));

  // R6
  stall_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (fire && rem) |=> !in_ready_o);
endmodule

// File: tb/tb_bdu_dispatch.sv
`timescale 1ns/1ps
module tb_bdu_dispatch;
  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_dual;
  logic [127:0] b0, b1;
  logic in_ready;
  logic [1:0] mem_v; logic [1:0][40:0] mem_i;
  logic [1:0] int_v; logic [1:0][40:0] int_i;
  logic [1:0] fp_v;  logic [1:0][40:0] fp_i;
  logic [2:0] br_v;  logic [2:0][40:0] br_i;
  logic fault;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  bdu_dispatch dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_dual_i(in_dual),
    .in_bundle0_i(b0), .in_bundle1_i(b1), .in_ready_o(in_ready),
    .mem_valid_o(mem_v), .mem_inst_o(mem_i), .int_valid_o(int_v), .int_inst_o(int_i),
    .fp_valid_o(fp_v), .fp_inst_o(fp_i), .br_valid_o(br_v), .br_inst_o(br_i),
    .fault_o(fault));

  function automatic logic [127:0] bund(logic [4:0] t, logic [40:0] s0, logic [40:0] s1, logic [40:0] s2);
    return {s2, s1, s0, t};
  endfunction

  function automatic logic [40:0] rw(int id);
    return 41'(64'h1_0000_0000 + id);
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_out(string req, logic [1:0] mv, logic [1:0] iv, logic [1:0] fv, logic [2:0] bv,
                            logic [40:0] m0, logic [40:0] m1, logic [40:0] i0, logic [40:0] i1,
                            logic [40:0] f0, logic [40:0] f1,
                            logic [40:0] x0, logic [40:0] x1, logic [40:0] x2);
    check({req, " mem valid"}, 64'(mem_v), 64'(mv));
    check({req, " int valid"}, 64'(int_v), 64'(iv));
    check({req, " fp valid"},  64'(fp_v),  64'(fv));
    check({req, " br valid"},  64'(br_v),  64'(bv));
    if (mv[0]) check({req, " mem0"}, 64'(mem_i[0]), 64'(m0));
    if (mv[1]) check({req, " mem1"}, 64'(mem_i[1]), 64'(m1));
    if (iv[0]) check({req, " int0"}, 64'(int_i[0]), 64'(i0));
    if (iv[1]) check({req, " int1"}, 64'(int_i[1]), 64'(i1));
    if (fv[0]) check({req, " fp0"},  64'(fp_i[0]),  64'(f0));
    if (fv[1]) check({req, " fp1"},  64'(fp_i[1]),  64'(f1));
    if (bv[0]) check({req, " br0"},  64'(br_i[0]),  64'(x0));
    if (bv[1]) check({req, " br1"},  64'(br_i[1]),  64'(x1));
    if (bv[2]) check({req, " br2"},  64'(br_i[2]),  64'(x2));
  endtask

  task automatic send(logic [127:0] x0, logic [127:0] x1, logic dual);
    in_valid = 1'b1; in_dual = dual; b0 = x0; b1 = x1;
    @(negedge clk);
    in_valid = 1'b0; in_dual = 1'b0;
  endtask

  task automatic t_reset();
    check("R10 ready in reset", 64'(in_ready), 64'(0));
    check("R10 fault in reset", 64'(fault), 64'(0));
    expect_out("R10 ports in reset", 2'b00, 2'b00, 2'b00, 3'b000, 0,0,0,0,0,0,0,0,0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 ready after one edge", 64'(in_ready), 64'(0));
    @(negedge clk);
    check("R10 ready after release", 64'(in_ready), 64'(1));
  endtask

  task automatic t_single();
    send(bund(5'd0, rw(1), rw(2), rw(3)), '0, 1'b0);
    expect_out("R1 R2 single MII", 2'b01, 2'b11, 2'b00, 3'b000, rw(1),0,rw(2),rw(3),0,0,0,0,0);
    check("R1 ready after single", 64'(in_ready), 64'(1));
    @(negedge clk);
    expect_out("R11 valid one cycle", 2'b00, 2'b00, 2'b00, 3'b000, 0,0,0,0,0,0,0,0,0);
  endtask

  task automatic t_pair();
    send(bund(5'd12, rw(11), rw(12), rw(13)), bund(5'd28, rw(14), rw(15), rw(16)), 1'b1);
    expect_out("R3 pair together", 2'b11, 2'b01, 2'b11, 3'b001,
               rw(11),rw(14),rw(13),0,rw(12),rw(15),rw(16),0,0);
    check("R3 ready after pair", 64'(in_ready), 64'(1));
    @(negedge clk);
  endtask

  task automatic t_stop_inside();
    send(bund(5'd2, rw(21), rw(22), rw(23)), '0, 1'b0);
    expect_out("R4 inner stop first", 2'b01, 2'b01, 2'b00, 3'b000, rw(21),0,rw(22),0,0,0,0,0,0);
    check("R6 ready low while held", 64'(in_ready), 64'(0));
    @(negedge clk);
    expect_out("R4 inner stop second", 2'b00, 2'b01, 2'b00, 3'b000, 0,0,rw(23),0,0,0,0,0,0);
    check("R6 ready back", 64'(in_ready), 64'(1));
    @(negedge clk);
  endtask

  task automatic t_stop_end();
    send(bund(5'd1, rw(31), rw(32), rw(33)), bund(5'd0, rw(34), rw(35), rw(36)), 1'b1);
    expect_out("R4 end stop first", 2'b01, 2'b11, 2'b00, 3'b000, rw(31),0,rw(32),rw(33),0,0,0,0,0);
    @(negedge clk);
    expect_out("R4 end stop second", 2'b01, 2'b11, 2'b00, 3'b000, rw(34),0,rw(35),rw(36),0,0,0,0,0);
    @(negedge clk);
  endtask

  task automatic t_conflict_order();
    send(bund(5'd8, rw(41), rw(42), rw(43)), bund(5'd24, rw(44), rw(45), rw(46)), 1'b1);
    in_valid = 1'b1; in_dual = 1'b0; b0 = bund(5'd0, rw(47), rw(48), rw(49));
    expect_out("R5 mem conflict first", 2'b11, 2'b01, 2'b00, 3'b000, rw(41),rw(42),rw(43),0,0,0,0,0,0);
    check("R6 stalled with input offered", 64'(in_ready), 64'(0));
    @(negedge clk);
    expect_out("R6 held before new", 2'b11, 2'b00, 2'b00, 3'b001, rw(44),rw(45),0,0,0,0,rw(46),0,0);
    check("R6 ready after drain", 64'(in_ready), 64'(1));
    @(negedge clk);
    in_valid = 1'b0;
    expect_out("R6 new after held", 2'b01, 2'b11, 2'b00, 3'b000, rw(47),0,rw(48),rw(49),0,0,0,0,0);
    @(negedge clk);
  endtask

  task automatic t_branch_full();
    send(bund(5'd22, rw(51), rw(52), rw(53)), bund(5'd18, rw(54), rw(55), rw(56)), 1'b1);
    expect_out("R5 branch ports full", 2'b01, 2'b00, 2'b00, 3'b111, rw(54),0,0,0,0,0,rw(51),rw(52),rw(53));
    @(negedge clk);
    expect_out("R5 branch remainder", 2'b00, 2'b00, 2'b00, 3'b011, 0,0,0,0,0,0,rw(55),rw(56),0);
    @(negedge clk);
  endtask

  task automatic t_illegal();
    send(bund(5'd6, rw(61), rw(62), rw(63)), bund(5'd0, rw(64), rw(65), rw(66)), 1'b1);
    check("R7 fault raised", 64'(fault), 64'(1));
    expect_out("R7 other bundle issues", 2'b01, 2'b11, 2'b00, 3'b000, rw(64),0,rw(65),rw(66),0,0,0,0,0);
    @(negedge clk);
    check("R7 fault one cycle", 64'(fault), 64'(0));
    send(bund(5'd31, rw(67), rw(68), rw(69)), '0, 1'b0);
    check("R7 fault lone illegal", 64'(fault), 64'(1));
    expect_out("R7 lone illegal silent", 2'b00, 2'b00, 2'b00, 3'b000, 0,0,0,0,0,0,0,0,0);
    check("R7 ready after illegal", 64'(in_ready), 64'(1));
    @(negedge clk);
  endtask

  task automatic t_nop();
    send(bund(5'd0, rw(71), 41'd0, rw(73)), '0, 1'b0);
    expect_out("R8 nop takes port", 2'b01, 2'b10, 2'b00, 3'b000, rw(71),0,0,rw(73),0,0,0,0,0);
    @(negedge clk);
  endtask

  task automatic t_long();
    send(bund(5'd4, rw(81), rw(82), rw(83)), bund(5'd0, rw(84), rw(85), rw(86)), 1'b1);
    expect_out("R9 long pair", 2'b11, 2'b11, 2'b00, 3'b000, rw(81),rw(84),rw(82),rw(83),0,0,0,0,0);
    @(negedge clk);
    expect_out("R9 after long", 2'b00, 2'b11, 2'b00, 3'b000, 0,0,rw(85),rw(86),0,0,0,0,0);
    @(negedge clk);
    send(bund(5'd16, rw(91), rw(92), rw(93)), bund(5'd4, rw(94), rw(95), rw(96)), 1'b1);
    expect_out("R9 long waits", 2'b11, 2'b01, 2'b00, 3'b001, rw(91),rw(94),rw(92),0,0,0,rw(93),0,0);
    @(negedge clk);
    expect_out("R9 long drains", 2'b00, 2'b11, 2'b00, 3'b000, 0,0,rw(95),rw(96),0,0,0,0,0);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_dual = 1'b0; b0 = '0; b1 = '0;
    repeat (3) @(negedge clk);
    t_reset();
    t_single();
    t_pair();
    t_stop_inside();
    t_stop_end();
    t_conflict_order();
    t_branch_full();
    t_illegal();
    t_nop();
    t_long();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule